// File: doc/BRIEF.md
# Partial-Reconfiguration Host Control Registers

This block is the host-facing register front end of a partial-reconfiguration data engine. Software reaches it through a simple read/write strobe bus of 64-bit words. Through it, software can:
- reset the engine and wait for the acknowledge;
- open a load operation for a chosen region;
- stream 32-bit bitstream words into an internal FIFO, gated by a credit count that it polls;
- announce that the push has ended.

The engine drains the FIFO towards a downstream consumer. It then ends the operation by itself: it drops the start request, which tells software that the load is over.

Failures are kept in a sticky error register that software clears by writing ones. A summary bit in the status word tells software when that register is worth reading. The consumer side is a valid/ready word stream. It also has two pulse inputs that report a CRC fault or an incompatible image. A read-only 128-bit identifier lets software check that an image suits this hardware before loading it.

A four-state controller sequences the block:
- `ST_IDLE` (code 0): ready for a new operation.
- `ST_RESET` (code 1): holds the FIFO flushed and shows the acknowledge.
- `ST_LOAD` (code 2): accepts data words.
- `ST_DRAIN` (code 3): push has ended and the FIFO is emptying.

The transitions are:
- Any state goes to `ST_RESET` while the reset request bit is set. This has priority over every other transition.
- `ST_RESET` goes to `ST_IDLE` when the request is cleared.
- `ST_IDLE` goes to `ST_LOAD` on a control write with the start bit set ("launch").
- `ST_LOAD` goes to `ST_DRAIN` on a control write with the push-complete bit set.
- `ST_DRAIN` goes to `ST_IDLE` once the FIFO is empty ("done").

Top module: `rcfg_ctrl_regs`

## Requirements
- R1: After reset, the control and error words read 0. The status word reads credit = FIFO depth, FIFO-empty flag set, host state 0. `snk_valid` is low and `cfg_region` is 0. Reads return data on `bus_rdata` one clock after `bus_rd`. Word index (`bus_addr`): 0 = control, 1 = status, 2 = data, 3 = error, 4 = identifier low, 5 = identifier high.
- R2: Setting control bit 0 (reset request) makes control bit 4 (acknowledge) read 1 and host state read 1. It also empties the FIFO, clears the start bit and returns all credits. Clearing bit 0 drops the acknowledge and returns host state to 0.
- R3: A control write with bit 12 set while idle starts an operation: bit 12 reads 1 and host state reads 2. `cfg_region` takes bits 9:8 of that write and holds them until the operation ends, even if the control region field is rewritten meanwhile.
- R4: While loading, each data write pushes `bus_wdata[31:0]` into the FIFO and ignores bits 63:32. The consumer receives the words on `snk_data` in write order.
- R5: Status bits 8:0 give the credit count, which equals the free FIFO entries. It falls by one per accepted data write and rises by one per word the consumer takes. Status bit 20 flags FIFO empty and bit 21 flags FIFO full.
- R6: A data write made outside the loading state, or while credits are zero, is dropped and sets error bit 3 (protocol). A write while loading with the FIFO full also sets error bit 4 (overflow).
- R7: A control write with bit 13 set while loading makes bit 13 read 1 and host state read 3. Once the FIFO is empty, bits 12 and 13 clear by themselves and host state returns to 0.
- R8: A pulse on `inj_crc_err` latches error bit 1, and a pulse on `inj_compat_err` latches error bit 2. A write to the error word clears exactly the bits written as one. Error bits 5 and 6 read 0.
- R9: Status bit 16 reads 1 whenever any error bit is latched.
- R10: Error bit 0 (previous operation failed) is set when an operation ends while any of error bits 1 to 4 is latched. It stays clear after a clean operation.
- R11: Word indices 4 and 5 return the low and high halves of the 128-bit interface identifier parameters.
- R12: Control bit 14 (image kind) and bits 63:32 (configuration data) are read/write. All reserved bits, the data word, and indices 6 and 7 read 0, and writes to reserved bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | 64-bit word index |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid the clock after `bus_rd` |
| snk_valid | output | 1 | FIFO holds a word for the consumer |
| snk_data | output | 32 | Head-of-FIFO bitstream word |
| snk_ready | input | 1 | Consumer takes the head word |
| inj_crc_err | input | 1 | Consumer reports a CRC fault |
| inj_compat_err | input | 1 | Consumer reports an incompatible image |
| cfg_region | output | 2 | Region of the operation in progress |

## Verification
A wrong controller state shows up at once, on the next status read, as a wrong host-state code or a start or push-complete bit that does not clear. A skew between the credit count and the FIFO fill level shows up on the status read after the next data write. It also shows as a dropped or extra word on `snk_data`, or as protocol and overflow flags raised at the wrong credit value. A sticky-error fault is visible on the error read directly after the triggering pulse or write-back. The completion flag (error bit 0) is checked on the first read after the start bit falls.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RESET = 2'd1,
        ST_LOAD  = 2'd2,
        ST_DRAIN = 2'd3
    } rcfg_state_e;

    // word indices on the register bus
    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_STAT  = 3'd1;
    localparam logic [2:0] REG_DATA  = 3'd2;
    localparam logic [2:0] REG_ERR   = 3'd3;
    localparam logic [2:0] REG_ID_LO = 3'd4;
    localparam logic [2:0] REG_ID_HI = 3'd5;

    // control word bit positions
    localparam int CB_RST   = 0;
    localparam int CB_ACK   = 4;
    localparam int CB_REG_L = 8;
    localparam int CB_START = 12;
    localparam int CB_PUSH  = 13;
    localparam int CB_KIND  = 14;
    localparam int CB_CFG_L = 32;

    // error bits
    localparam int EB_PREV  = 0;
    localparam int EB_CRC   = 1;
    localparam int EB_COMP  = 2;
    localparam int EB_PROTO = 3;
    localparam int EB_OVF   = 4;
    localparam int ERR_W    = 5;

    localparam int CREDIT_W = 9;

endpackage

// File: rtl/rcfg_fifo.sv
module rcfg_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] free
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CAP);
    assign free  = CAP - count;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);                                              // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);                                              // R4
    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        free <= CAP);                                                 // R5

endmodule

// File: rtl/rcfg_fsm.sv
module rcfg_fsm
    import rcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rst_req,
    input  logic        start_wr,
    input  logic        push_wr,
    input  logic        fifo_empty,
    output rcfg_state_e state,
    output logic        ack,
    output logic        start_bit,
    output logic        push_bit,
    output logic        flush,
    output logic        launch,
    output logic        done
);

    rcfg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (rst_req) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET: state_d = ST_IDLE;
                ST_IDLE:  if (start_wr)   state_d = ST_LOAD;
                ST_LOAD:  if (push_wr)    state_d = ST_DRAIN;
                ST_DRAIN: if (fifo_empty) state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state     = state_q;
        ack       = (state_q == ST_RESET);
        flush     = (state_q == ST_RESET);
        start_bit = (state_q == ST_LOAD) || (state_q == ST_DRAIN);
        push_bit  = (state_q == ST_DRAIN);
        launch    = (state_q == ST_IDLE) && start_wr && !rst_req;
        done      = (state_q == ST_DRAIN) && fifo_empty && !rst_req;
    end

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(rst_req));                               // R2
    AST_DRAIN_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_bit) |-> $past(push_wr));                          // R7

endmodule

// File: rtl/rcfg_ctrl_regs.sv
module rcfg_ctrl_regs
    import rcfg_pkg::*;
#(
    parameter int          FIFO_DEPTH = 16,
    parameter logic [63:0] IFC_ID_LO  = 64'h0,
    parameter logic [63:0] IFC_ID_HI  = 64'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [63:0] bus_wdata,
    output logic [63:0] bus_rdata,
    output logic        snk_valid,
    output logic [31:0] snk_data,
    input  logic        snk_ready,
    input  logic        inj_crc_err,
    input  logic        inj_compat_err,
    output logic [1:0]  cfg_region
);

    // FIFO_DEPTH must not exceed 511 so the credit fits its 9-bit field
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    rcfg_state_e      state;
    logic             ack, start_bit, push_bit, flush, launch, done;
    logic             fifo_empty, fifo_full, fifo_push, fifo_pop;
    logic [CNT_W-1:0] fifo_free;

    logic             rst_q, kind_q;
    logic [1:0]       region_fld, region_act;
    logic [31:0]      cfg_q;
    logic [ERR_W-1:0] err_q, err_set, err_clr;
    logic [63:0]      rd_word, rdata_q;

    logic wr_ctrl, wr_data, wr_err;
    assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
    assign wr_data = bus_wr && (bus_addr == REG_DATA);
    assign wr_err  = bus_wr && (bus_addr == REG_ERR);

    rcfg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_req    (rst_q),
        .start_wr   (wr_ctrl && bus_wdata[CB_START]),
        .push_wr    (wr_ctrl && bus_wdata[CB_PUSH]),
        .fifo_empty (fifo_empty),
        .state      (state),
        .ack        (ack),
        .start_bit  (start_bit),
        .push_bit   (push_bit),
        .flush      (flush),
        .launch     (launch),
        .done       (done)
    );

    assign fifo_push = wr_data && (state == ST_LOAD) && !fifo_full;
    assign fifo_pop  = snk_valid && snk_ready;

    rcfg_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (fifo_push),
        .din   (bus_wdata[31:0]),
        .pop   (fifo_pop),
        .dout  (snk_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .free  (fifo_free)
    );

    assign snk_valid  = !fifo_empty;
    assign cfg_region = region_act;

    // control fields held for the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q      <= 1'b0;
            kind_q     <= 1'b0;
            region_fld <= '0;
            cfg_q      <= '0;
            region_act <= '0;
        end else begin
            if (wr_ctrl) begin
                rst_q      <= bus_wdata[CB_RST];
                kind_q     <= bus_wdata[CB_KIND];
                region_fld <= bus_wdata[CB_REG_L +: 2];
                cfg_q      <= bus_wdata[CB_CFG_L +: 32];
            end
            if (launch) region_act <= bus_wdata[CB_REG_L +: 2];
        end
    end

    // sticky errors, write-one-to-clear; a new event wins over a clear
    always_comb begin
        err_set           = '0;
        err_set[EB_CRC]   = inj_crc_err;
        err_set[EB_COMP]  = inj_compat_err;
        err_set[EB_PROTO] = wr_data && !fifo_push;
        err_set[EB_OVF]   = wr_data && (state == ST_LOAD) && fifo_full;
        err_set[EB_PREV]  = done && (|(err_q[ERR_W-1:1] | err_set[ERR_W-1:1]));
        err_clr           = wr_err ? bus_wdata[ERR_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~err_clr) | err_set;
    end

    always_comb begin
        rd_word = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                rd_word[CB_RST]          = rst_q;
                rd_word[CB_ACK]          = ack;
                rd_word[CB_REG_L +: 2]   = region_fld;
                rd_word[CB_START]        = start_bit;
                rd_word[CB_PUSH]         = push_bit;
                rd_word[CB_KIND]         = kind_q;
                rd_word[CB_CFG_L +: 32]  = cfg_q;
            end
            REG_STAT: begin
                rd_word[CREDIT_W-1:0] = CREDIT_W'(fifo_free);
                rd_word[16]           = |err_q;
                rd_word[22:20]        = {1'b0, fifo_full, fifo_empty};
                rd_word[27:24]        = {2'b00, state};
            end
            REG_ERR:   rd_word[ERR_W-1:0] = err_q;
            REG_ID_LO: rd_word = IFC_ID_LO;
            REG_ID_HI: rd_word = IFC_ID_HI;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_word;
    end
    assign bus_rdata = rdata_q;

    AST_REGION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        start_bit && $past(start_bit) |-> $stable(region_act));       // R3
    AST_START_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_bit) && !$past(rst_q) |-> fifo_empty);            // R7
    AST_DROP_FLAGS_PROTO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && (state != ST_LOAD) |=> err_q[EB_PROTO]);           // R6
    AST_PREV_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_q[EB_CRC] |=> err_q[EB_PREV]);                    // R10

endmodule

// File: tb/test_rcfg_ctrl_regs.sv
module test_rcfg_ctrl_regs;

    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 4;
    localparam logic [63:0] ID_LO      = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] ID_HI      = 64'hFEDC_BA98_7654_3210;
    localparam logic [31:0] CFG        = 32'hA5A5_5A5A;

    logic        clk = 0, rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [2:0]  bus_addr = 0;
    logic [63:0] bus_wdata = 0;
    logic [63:0] bus_rdata;
    logic        snk_valid, snk_ready = 0;
    logic [31:0] snk_data;
    logic        inj_crc_err = 0, inj_compat_err = 0;
    logic [1:0]  cfg_region;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    logic [63:0] exp_rd_q [$];
    string       tag_rd_q [$];
    logic [31:0] exp_wd_q [$];
    logic        rd_pending = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcfg_ctrl_regs #(.FIFO_DEPTH(DEPTH), .IFC_ID_LO(ID_LO), .IFC_ID_HI(ID_HI)) i_rcfg_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .snk_valid(snk_valid),
        .snk_data(snk_data), .snk_ready(snk_ready), .inj_crc_err(inj_crc_err),
        .inj_compat_err(inj_compat_err), .cfg_region(cfg_region)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] stat(input int cr, input bit op, input bit full,
                                         input bit empty, input int host);
        logic [63:0] w = '0;
        w[8:0]   = 9'(cr);
        w[16]    = op;
        w[21]    = full;
        w[20]    = empty;
        w[27:24] = 4'(host);
        return w;
    endfunction

    // driver tasks
    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        exp_rd_q.push_back(exp);
        tag_rd_q.push_back(tag);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic push_word(input logic [31:0] w, input bit expect_out);
        wr(3'd2, {32'hDEAD_BEEF, w});
        if (expect_out) exp_wd_q.push_back(w);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitors
    always @(posedge clk) rd_pending <= bus_rd;

    always @(negedge clk) begin
        if (rd_pending) begin
            if (exp_rd_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R1: unexpected read data actual %h expected none", bus_rdata);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_rd_q.pop_front();
                t = tag_rd_q.pop_front();
                check(bus_rdata, e, t);
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n && snk_valid && snk_ready) begin
            if (exp_wd_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R4: extra word actual %h expected none", snk_data);
            end else begin
                check({32'h0, snk_data}, {32'h0, exp_wd_q.pop_front()}, "R4 word order");
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);

        // R1 reset state
        rd(3'd0, 64'h0, "R1 ctrl");
        rd(3'd1, stat(DEPTH, 0, 0, 1, 0), "R1 status");
        rd(3'd3, 64'h0, "R1 error");
        check({63'h0, snk_valid}, 64'h0, "R1 snk_valid");
        check({62'h0, cfg_region}, 64'h0, "R1 cfg_region");

        // R11 identifier
        rd(3'd4, ID_LO, "R11 id low");
        rd(3'd5, ID_HI, "R11 id high");

        // R12 read/write fields and reserved bits
        wr(3'd0, {CFG, 32'h0000_40EE});
        rd(3'd0, {CFG, 32'h0000_4000}, "R12 ctrl reserved");
        rd(3'd7, 64'h0, "R12 unused index");
        rd(3'd2, 64'h0, "R12 data reads zero");

        // R6 data write while idle is dropped
        push_word(32'h0000_1234, 0);
        rd(3'd3, 64'h8, "R6 protocol error idle");
        rd(3'd1, stat(DEPTH, 1, 0, 1, 0), "R9 op status");
        wr(3'd3, 64'hFFFF_FFFF_FFFF_FFF7);
        rd(3'd3, 64'h8, "R8 w1c keeps unwritten bit");
        wr(3'd3, 64'h8);
        rd(3'd3, 64'h0, "R8 w1c clears");
        rd(3'd1, stat(DEPTH, 0, 0, 1, 0), "R9 op status clear");

        // R2 reset handshake
        wr(3'd0, {CFG, 32'h0000_4001});
        wait_cyc(3);
        rd(3'd0, {CFG, 32'h0000_4011}, "R2 ack set");
        rd(3'd1, stat(DEPTH, 0, 0, 1, 1), "R2 host reset state");
        wr(3'd0, {CFG, 32'h0000_4000});
        wait_cyc(2);
        rd(3'd0, {CFG, 32'h0000_4000}, "R2 ack cleared");
        rd(3'd1, stat(DEPTH, 0, 0, 1, 0), "R2 back to idle");

        // R3 start with region 2, then rewrite field
        wr(3'd0, {CFG, 32'h0000_5200});
        wait_cyc(1);
        check({62'h0, cfg_region}, 64'd2, "R3 region sampled");
        rd(3'd0, {CFG, 32'h0000_5200}, "R3 start bit");
        rd(3'd1, stat(DEPTH, 0, 0, 1, 2), "R3 host loading");
        wr(3'd0, {CFG, 32'h0000_5100});
        wait_cyc(1);
        check({62'h0, cfg_region}, 64'd2, "R3 region held");
        rd(3'd0, {CFG, 32'h0000_5100}, "R3 field rewritable");

        // R4/R5 fill FIFO with consumer stalled
        snk_ready = 0;
        push_word(32'h1111_0001, 1);
        push_word(32'h2222_0002, 1);
        rd(3'd1, stat(DEPTH - 2, 0, 0, 0, 2), "R5 credit after two");
        push_word(32'h3333_0003, 1);
        push_word(32'h4444_0004, 1);
        rd(3'd1, stat(0, 0, 1, 0, 2), "R5 credit zero full");

        // R6 overrun
        push_word(32'h9999_0009, 0);
        rd(3'd3, 64'h18, "R6 overflow and protocol");
        rd(3'd1, stat(0, 1, 1, 0, 2), "R6 nothing pushed");
        wr(3'd3, 64'h18);

        // R8 injected errors
        @(negedge clk); inj_crc_err = 1;
        @(negedge clk); inj_crc_err = 0;
        rd(3'd3, 64'h2, "R8 crc latched");
        @(negedge clk); inj_compat_err = 1;
        @(negedge clk); inj_compat_err = 0;
        rd(3'd3, 64'h6, "R8 compat latched");
        rd(3'd1, stat(0, 1, 1, 0, 2), "R9 op status set");

        // R4/R5 drain
        @(negedge clk); snk_ready = 1;
        wait_cyc(8);
        rd(3'd1, stat(DEPTH, 1, 0, 1, 2), "R5 credits returned");

        // R7 push complete and self-clearing start
        @(negedge clk); snk_ready = 0;
        push_word(32'h5555_0005, 1);
        push_word(32'h6666_0006, 1);
        wr(3'd0, {CFG, 32'h0000_7100});
        wait_cyc(1);
        rd(3'd0, {CFG, 32'h0000_7100}, "R7 push bit set");
        rd(3'd1, stat(DEPTH - 2, 1, 0, 0, 3), "R7 draining");
        check({62'h0, cfg_region}, 64'd2, "R3 region held in drain");
        @(negedge clk); snk_ready = 1;
        wait_cyc(6);
        rd(3'd0, {CFG, 32'h0000_4100}, "R7 start self-cleared");
        rd(3'd1, stat(DEPTH, 1, 0, 1, 0), "R7 host idle");
        rd(3'd3, 64'h7, "R10 previous op error");
        wr(3'd3, 64'h7F);
        rd(3'd3, 64'h0, "R8 all cleared");
        rd(3'd1, stat(DEPTH, 0, 0, 1, 0), "R9 op status clear");

        // R10 clean operation
        wr(3'd0, {CFG, 32'h0000_5000});
        wait_cyc(1);
        check({62'h0, cfg_region}, 64'd0, "R3 region new op");
        push_word(32'h7777_0007, 1);
        wr(3'd0, {CFG, 32'h0000_7000});
        wait_cyc(6);
        rd(3'd0, {CFG, 32'h0000_4000}, "R7 clean op done");
        rd(3'd3, 64'h0, "R10 no error after clean op");

        // R2 reset during load flushes FIFO
        @(negedge clk); snk_ready = 0;
        wr(3'd0, {CFG, 32'h0000_5000});
        push_word(32'h8888_0008, 0);
        push_word(32'h8888_0009, 0);
        wr(3'd0, {CFG, 32'h0000_5001});
        wait_cyc(3);
        check({63'h0, snk_valid}, 64'h0, "R2 FIFO flushed");
        rd(3'd0, {CFG, 32'h0000_4011}, "R2 start cleared by reset");
        rd(3'd1, stat(DEPTH, 0, 0, 1, 1), "R2 credits restored");
        wr(3'd0, {CFG, 32'h0000_4000});
        wait_cyc(2);
        rd(3'd1, stat(DEPTH, 0, 0, 1, 0), "R2 idle again");

        wait_cyc(4);
        if (exp_rd_q.size() != 0 || exp_wd_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R4: pending items actual %0d expected 0",
                     exp_rd_q.size() + exp_wd_q.size());
        end
        finish_run();
    end

endmodule